// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four level-sensitive PCI interrupt lines onto a bank of sixteen inputs of a legacy interrupt controller. A device reports a level change with its device number, the interrupt pin it uses (INTA to INTD) and the new level. A slot-dependent rotation turns that pin into one of the four shared lines, and the block stores the line's level. Spreading devices across the lines in this way keeps them from all piling onto INTA.

Each line has its own routing byte in a byte-wide configuration register space. A routing byte either names one of the sixteen controller inputs or switches the line off. Every controller input is driven combinationally as the OR of the stored levels of all enabled lines that point at it. Any number of lines may therefore share one input. Two more registers, a command byte and a status high byte, come up with fixed reset values.

Top module: `intline_router`

## Requirements
- R1: After reset all routing bytes read 0x80, the command byte reads 0x07, the status high byte reads 0x02, every stored line level is zero and `irq_out` is all zero.
- R2: `swz_line` equals (`evt_pin` + `evt_dev` − 1) mod 4 at all times, combinationally. Pin code 0 stands for INTA and 3 for INTD.
- R3: At a clock edge with `evt_valid` high, the stored level of line `swz_line` takes `evt_level`. The other lines keep their levels.
- R4: Line n's routing byte sits at configuration address 0x60 + n. A write at a clock edge with `cfg_we` high stores the whole byte, and the byte reads back unchanged on `cfg_rdata`.
- R5: A routing byte with bit 7 set disables its line. That line then drives no bit of `irq_out`, whatever its level.
- R6: With bit 7 clear, bits 3:0 of the routing byte select the output bit. Bits 6:4 are ignored.
- R7: Each bit of `irq_out` is the OR of the stored levels of every enabled line routed to it. While two lines share one output, dropping one of them keeps the output high as long as the other stays high.
- R8: When a routing byte is rewritten, the outputs follow from the edge that stores it. The old target drops and the new target takes the line's level, with no further delay.
- R9: The command byte at address 0x04 is writable and readable. The status high byte at address 0x07 always reads 0x02 and ignores writes. Any other address reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| evt_valid | input | 1 | A device level change is presented |
| evt_dev | input | 5 | Device number of the reporting device |
| evt_pin | input | 2 | Interrupt pin of the device (0 = INTA … 3 = INTD) |
| evt_level | input | 1 | New level of that pin |
| swz_line | output | 2 | Line selected by the slot rotation |
| irq_out | output | 16 | Levels driven to the interrupt controller inputs |

## Verification
The hardest case to reach is two lines sharing one output while one of them drops. The bench has to set up a second route with ignored high bits that still lands on the same output, and raise both lines through device numbers the rotation maps to distinct lines. Only then can it lower one line and see the output stay high. A retarget is also exercised while the line is high. This shows that the old bit falls and the new bit rises at the same edge. Device numbers 0 and 31 probe the wrap-around of the rotation.

// File: rtl/intline_router_pkg.sv
package intline_router_pkg;

   localparam logic [7:0] ROUTE_OFF_RST = 8'h80;
   localparam logic [7:0] CMD_RST       = 8'h07;
   localparam logic [7:0] STAT_HI_VAL   = 8'h02;
   localparam int         ROUTE_DIS_BIT = 7;
   localparam int         DEV_W         = 5;

endpackage

// File: rtl/intline_swizzle.sv
module intline_swizzle #(
   parameter int N_LINES = 4,
   parameter int DEV_W   = 5,
   localparam int LINE_W = $clog2(N_LINES)
) (
   input  logic [DEV_W-1:0]  dev,
   input  logic [LINE_W-1:0] pin,
   output logic [LINE_W-1:0] line
);

   // rotation by slot: device 1 maps pins straight through
   always_comb begin
      line = pin + LINE_W'(dev) - LINE_W'(1);
   end

endmodule

// File: rtl/intline_cfg_regs.sv
module intline_cfg_regs
   import intline_router_pkg::*;
#(
   parameter int             N_LINES      = 4,
   parameter int             N_OUTS       = 16,
   parameter int             ADDR_W       = 8,
   parameter logic [ADDR_W-1:0] ROUTE_BASE   = 8'h60,
   parameter logic [ADDR_W-1:0] CMD_ADDR     = 8'h04,
   parameter logic [ADDR_W-1:0] STAT_HI_ADDR = 8'h07,
   localparam int            TGT_W        = $clog2(N_OUTS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [7:0]                wdata,
   output logic [7:0]                rdata,
   output logic [N_LINES-1:0]        route_en,
   output logic [N_LINES*TGT_W-1:0]  route_tgt
);

   logic [7:0] route_q [N_LINES];
   logic [7:0] cmd_q;

   for (genvar gi = 0; gi < N_LINES; gi++) begin : g_route
      localparam logic [ADDR_W-1:0] MY_ADDR = ROUTE_BASE + ADDR_W'(gi);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            route_q[gi] <= ROUTE_OFF_RST;
         end else if (we && addr == MY_ADDR) begin
            route_q[gi] <= wdata;
         end
      end

      assign route_en[gi]                   = ~route_q[gi][ROUTE_DIS_BIT];
      assign route_tgt[gi*TGT_W +: TGT_W]   = route_q[gi][TGT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= CMD_RST;
      end else if (we && addr == CMD_ADDR) begin
         cmd_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == CMD_ADDR) begin
         rdata = cmd_q;
      end
      if (addr == STAT_HI_ADDR) begin
         rdata = STAT_HI_VAL;
      end
      for (int li = 0; li < N_LINES; li++) begin
         if (addr == ROUTE_BASE + ADDR_W'(li)) begin
            rdata = route_q[li];
         end
      end
   end

endmodule

// File: rtl/intline_or_matrix.sv
module intline_or_matrix #(
   parameter int N_LINES = 4,
   parameter int N_OUTS  = 16,
   localparam int TGT_W  = $clog2(N_OUTS)
) (
   input  logic [N_LINES-1:0]       lvl,
   input  logic [N_LINES-1:0]       route_en,
   input  logic [N_LINES*TGT_W-1:0] route_tgt,
   output logic [N_OUTS-1:0]        irq
);

   for (genvar go = 0; go < N_OUTS; go++) begin : g_out
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int li = 0; li < N_LINES; li++) begin
            if (route_en[li] && route_tgt[li*TGT_W +: TGT_W] == TGT_W'(go)) begin
               hit = hit | lvl[li];
            end
         end
      end
      assign irq[go] = hit;
   end

endmodule

// File: rtl/intline_router.sv
module intline_router
   import intline_router_pkg::*;
#(
   parameter int N_LINES = 4,
   parameter int N_OUTS  = 16,
   parameter int ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] ROUTE_BASE   = 8'h60,
   parameter logic [ADDR_W-1:0] CMD_ADDR     = 8'h04,
   parameter logic [ADDR_W-1:0] STAT_HI_ADDR = 8'h07,
   localparam int LINE_W = $clog2(N_LINES),
   localparam int TGT_W  = $clog2(N_OUTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              evt_valid,
   input  logic [DEV_W-1:0]  evt_dev,
   input  logic [LINE_W-1:0] evt_pin,
   input  logic              evt_level,
   output logic [LINE_W-1:0] swz_line,
   output logic [N_OUTS-1:0] irq_out
);

   // elaboration checks on the parameter set
   if (N_LINES < 2 || N_LINES != (1 << LINE_W)) begin : g_bad_lines
      $error("N_LINES must be a power of two of at least 2");
   end
   if (N_OUTS < 2 || TGT_W > ROUTE_DIS_BIT) begin : g_bad_outs
      $error("N_OUTS must fit below the disable bit of a routing byte");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must hold a byte offset");
   end

   logic [N_LINES-1:0]       lvl_q;
   logic [N_LINES-1:0]       route_en;
   logic [N_LINES*TGT_W-1:0] route_tgt;

   intline_swizzle #(
      .N_LINES (N_LINES),
      .DEV_W   (DEV_W)
   ) u_swz (
      .dev  (evt_dev),
      .pin  (evt_pin),
      .line (swz_line)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (evt_valid) begin
         lvl_q[swz_line] <= evt_level;
      end
   end

   intline_cfg_regs #(
      .N_LINES      (N_LINES),
      .N_OUTS       (N_OUTS),
      .ADDR_W       (ADDR_W),
      .ROUTE_BASE   (ROUTE_BASE),
      .CMD_ADDR     (CMD_ADDR),
      .STAT_HI_ADDR (STAT_HI_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .route_en  (route_en),
      .route_tgt (route_tgt)
   );

   intline_or_matrix #(
      .N_LINES (N_LINES),
      .N_OUTS  (N_OUTS)
   ) u_mtx (
      .lvl       (lvl_q),
      .route_en  (route_en),
      .route_tgt (route_tgt),
      .irq       (irq_out)
   );

endmodule

// File: rtl/intline_router_chk.sv
module intline_router_chk #(
   parameter int N_LINES = 4,
   parameter int N_OUTS  = 16,
   parameter int ADDR_W  = 8,
   parameter int DEV_W   = 5,
   parameter logic [ADDR_W-1:0] ROUTE_BASE   = 8'h60,
   parameter logic [ADDR_W-1:0] STAT_HI_ADDR = 8'h07,
   localparam int LINE_W = $clog2(N_LINES),
   localparam int TGT_W  = $clog2(N_OUTS)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cfg_we,
   input logic [ADDR_W-1:0]         cfg_addr,
   input logic [7:0]                cfg_wdata,
   input logic [7:0]                cfg_rdata,
   input logic                      evt_valid,
   input logic [DEV_W-1:0]          evt_dev,
   input logic [LINE_W-1:0]         evt_pin,
   input logic                      evt_level,
   input logic [LINE_W-1:0]         swz_line,
   input logic [N_LINES-1:0]        lvl_q,
   input logic [N_LINES-1:0]        route_en,
   input logic [N_LINES*TGT_W-1:0]  route_tgt,
   input logic [N_OUTS-1:0]         irq_out
);

   AST_SWZ_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      swz_line == LINE_W'(int'(evt_pin) + int'(evt_dev) + N_LINES - 1)); // R2

   AST_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |=> lvl_q[$past(swz_line)] == $past(evt_level)); // R3

   AST_STAT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_addr == STAT_HI_ADDR |-> cfg_rdata == 8'h02); // R9

   AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      route_en == '0 |-> irq_out == '0); // R5

   AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out != '0 |-> lvl_q != '0); // R7

   for (genvar gl = 0; gl < N_LINES; gl++) begin : g_line
      AST_ROUTE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_addr == ROUTE_BASE + ADDR_W'(gl))
         |=> ((cfg_addr == $past(cfg_addr)) -> (cfg_rdata == $past(cfg_wdata)))); // R4

      AST_LINE_REACHES: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl_q[gl] && route_en[gl] && int'(route_tgt[gl*TGT_W +: TGT_W]) < N_OUTS)
         |-> irq_out[route_tgt[gl*TGT_W +: TGT_W]]); // R8
   end

endmodule

bind intline_router intline_router_chk #(
   .N_LINES      (N_LINES),
   .N_OUTS       (N_OUTS),
   .ADDR_W       (ADDR_W),
   .DEV_W        (intline_router_pkg::DEV_W),
   .ROUTE_BASE   (ROUTE_BASE),
   .STAT_HI_ADDR (STAT_HI_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .evt_valid (evt_valid),
   .evt_dev   (evt_dev),
   .evt_pin   (evt_pin),
   .evt_level (evt_level),
   .swz_line  (swz_line),
   .lvl_q     (lvl_q),
   .route_en  (route_en),
   .route_tgt (route_tgt),
   .irq_out   (irq_out)
);

// File: tb/intline_router_test.sv
module intline_router_test;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [7:0]  cfg_addr;
   logic [7:0]  cfg_wdata;
   logic [7:0]  cfg_rdata;
   logic        evt_valid;
   logic [4:0]  evt_dev;
   logic [1:0]  evt_pin;
   logic        evt_level;
   logic [1:0]  swz_line;
   logic [15:0] irq_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(CLK_P/2) clk = ~clk;

   intline_router uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .evt_valid (evt_valid),
      .evt_dev   (evt_dev),
      .evt_pin   (evt_pin),
      .evt_level (evt_level),
      .swz_line  (swz_line),
      .irq_out   (irq_out)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1;
      chk(req, 32'(cfg_rdata), 32'(exp));
   endtask

   task automatic ev(logic [4:0] dev, logic [1:0] pin, logic lvl);
      @(negedge clk);
      evt_valid = 1'b1; evt_dev = dev; evt_pin = pin; evt_level = lvl;
      @(negedge clk);
      evt_valid = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      for (int i = 0; i < 4; i++) rd_chk("R1 route reset", 8'(8'h60 + i), 8'h80);
      rd_chk("R1 command reset", 8'h04, 8'h07);
      rd_chk("R1 status high reset", 8'h07, 8'h02);
      chk("R1 outputs idle", 32'(irq_out), 32'h0);
   endtask

   task automatic t_swizzle();
      @(negedge clk);
      evt_dev = 5'd0;  evt_pin = 2'd0; #1 chk("R2 dev0 pinA", 32'(swz_line), 32'd3);
      evt_dev = 5'd3;  evt_pin = 2'd2; #1 chk("R2 dev3 pinC", 32'(swz_line), 32'd0);
      evt_dev = 5'd31; evt_pin = 2'd3; #1 chk("R2 dev31 pinD", 32'(swz_line), 32'd1);
      evt_dev = 5'd1;  evt_pin = 2'd1; #1 chk("R2 dev1 pinB", 32'(swz_line), 32'd1);
   endtask

   task automatic t_disabled();
      ev(5'd1, 2'd0, 1'b1);                       // line 0 high
      chk("R5 disabled line silent", 32'(irq_out), 32'h0);
   endtask

   task automatic t_route();
      wr(8'h60, 8'h05);
      chk("R4 route line0 to 5", 32'(irq_out), 32'h0020);
      rd_chk("R4 readback", 8'h60, 8'h05);
   endtask

   task automatic t_share();
      wr(8'h61, 8'h75);                           // R6 bits 6:4 ignored
      ev(5'd1, 2'd1, 1'b1);                       // line 1 high
      chk("R6 high bits ignored", 32'(irq_out), 32'h0020);
      rd_chk("R4 readback full byte", 8'h61, 8'h75);
      ev(5'd1, 2'd0, 1'b0);                       // line 0 low
      chk("R7 shared stays high", 32'(irq_out), 32'h0020);
      ev(5'd1, 2'd1, 1'b0);                       // line 1 low
      chk("R7 shared drops", 32'(irq_out), 32'h0);
   endtask

   task automatic t_disable_bit();
      wr(8'h61, 8'h85);
      ev(5'd1, 2'd1, 1'b1);
      chk("R5 bit7 disables", 32'(irq_out), 32'h0);
      wr(8'h61, 8'h05);
      chk("R5 re-enable", 32'(irq_out), 32'h0020);
      ev(5'd1, 2'd1, 1'b0);
      chk("R3 line1 low", 32'(irq_out), 32'h0);
   endtask

   task automatic t_reroute();
      ev(5'd1, 2'd0, 1'b1);
      chk("R7 line0 on 5", 32'(irq_out), 32'h0020);
      wr(8'h60, 8'h0C);
      chk("R8 retarget to 12", 32'(irq_out), 32'h1000);
      wr(8'h60, 8'h00);
      chk("R8 retarget to 0", 32'(irq_out), 32'h0001);
      wr(8'h60, 8'h0F);
      chk("R8 retarget to 15", 32'(irq_out), 32'h8000);
      ev(5'd2, 2'd3, 1'b0);                       // dev2 pinD rotates to line 0
      chk("R3 rotated event clears line0", 32'(irq_out), 32'h0);
      ev(5'd0, 2'd1, 1'b1);                       // dev0 pinB rotates to line 0
      chk("R3 rotated event sets line0", 32'(irq_out), 32'h8000);
   endtask

   task automatic t_cfg();
      wr(8'h04, 8'h00);
      rd_chk("R9 command write", 8'h04, 8'h00);
      wr(8'h07, 8'hFF);
      rd_chk("R9 status read-only", 8'h07, 8'h02);
      wr(8'h30, 8'hAA);
      rd_chk("R9 unused address", 8'h30, 8'h00);
      rd_chk("R9 route2 untouched", 8'h62, 8'h80);
      chk("R9 outputs untouched", 32'(irq_out), 32'h8000);
   endtask

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      evt_valid = 1'b0; evt_dev = '0; evt_pin = '0; evt_level = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_swizzle();
      t_disabled();
      t_route();
      t_share();
      t_disable_bit();
      t_reroute();
      t_cfg();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule